// File: doc/BRIEF.md
# AVB Ingress Frame Classifier

This block sits on the ingress side of a switch and looks at one frame descriptor per cycle. For each frame it decides whether the frame is ordinary (legacy) traffic, low-class stream traffic (class B) or high-class stream traffic (class A). It also picks the egress queue priority for the frame and decides whether the frame is admitted or dropped. Two kinds of configuration steer the result. One switch-wide register pairs one frame priority with each stream class and names the queue that class uses. One register per port selects how strict stream membership is on that port: off, priority only, priority plus a static-stream flag from the address table, or all of that plus a check that the source port appears in the frame's destination vector.

Stream frames, and management frames when this is enabled, draw from a shared pool of isochronous buffer pointers. The pool is capped by a programmable threshold. Software typically writes the port count times 64 as the threshold. A release pulse returns one pointer to the pool. A zero threshold turns the reservation off. Configuration is written through a plain address/data/write-enable port.

Register map (address, meaning):
- 0: priority map. Bits 14:12 hold the high-class frame priority and bits 10:8 its queue. Bits 6:4 hold the low-class frame priority and bits 2:0 its queue. The reset value is 0x5342.
- 1: pool control. Bits 9:0 hold the threshold. Bit 15 sends management frames through the pool.
- 2+p: configuration of port p. Bits 15:14 hold the mode. Bit 12 demotes bad stream frames. Bit 10 drops bad stream frames.

Top module: `avb_frame_classifier`

## Requirements
- R1: After reset, res_valid is 0, every port is in mode 0, the pool threshold is 0 and the priority map reads 0x5342. With that map, frame priority 5 on a standard port gives class 2 with queue 3, and priority 4 gives class 1 with queue 2.
- R2: On a port in mode 0, every frame gets class 0 (legacy), its queue priority equals its frame priority, and it is admitted.
- R3: On a port in mode 1, a frame whose priority equals the high-class field (bits 14:12) gets class 2 with the queue from bits 10:8. A frame whose priority equals the low-class field (bits 6:4) gets class 1 with the queue from bits 2:0. Any other priority gives class 0 with queue equal to the priority.
- R4: When both class fields hold the same frame priority, a matching frame gets class 2 with the high-class queue.
- R5: On a port in mode 2, a matching frame counts as a stream frame only when frm_static_avb is 1. Otherwise it is a bad stream frame.
- R6: On a port in mode 3, a matching frame counts as a stream frame only when frm_static_avb is 1 and bit frm_src of frm_dst_vec is 1. Otherwise it is a bad stream frame.
- R7: A bad stream frame is dropped (class 0, queue equal to its priority, res_admit 0) when port bit 10 is set. Otherwise, if port bit 12 is set, it is admitted as class 0 with queue equal to its priority. With neither bit set it keeps its matched stream class.
- R8: With a nonzero threshold, a frame that needs a pointer is admitted only while the pointers in use are below the threshold. Each such admission adds one pointer in use. A frame refused by the pool has res_admit 0 and keeps its class and queue.
- R9: Each cycle with ptr_release at 1 removes one pointer in use, never going below zero. An admission and a release in the same cycle leave the count unchanged.
- R10: A class 0 management frame needs a pointer only when pool-control bit 15 is 1. Otherwise it is admitted without drawing from the pool.
- R11: With a threshold of 0, frames that would need a pointer are always admitted and the pointers in use do not grow.
- R12: The result for a frame presented with frm_valid at 1 appears with res_valid at 1 on the next clock. Cycles without frm_valid give res_valid at 0. A frame is judged with the configuration held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address (0 map, 1 pool, 2+p port p) |
| cfg_wdata | input | 16 | Register write data |
| frm_valid | input | 1 | Frame descriptor valid strobe |
| frm_pri | input | 3 | Frame priority |
| frm_src | input | PORT_W | Source port number |
| frm_dst_vec | input | NUM_PORTS | Destination port vector |
| frm_static_avb | input | 1 | Static stream flag from address lookup |
| frm_mgmt | input | 1 | Management frame flag |
| ptr_release | input | 1 | Return one isochronous pointer |
| res_valid | output | 1 | Result valid, one clock after frm_valid |
| res_class | output | 2 | 0 legacy, 1 low class, 2 high class |
| res_qpri | output | 3 | Egress queue priority |
| res_admit | output | 1 | 1 admit, 0 drop |

## Verification
The bench builds the block with NUM_PORTS set to 4. With four ports, every source port can be swept against every mode, filter and discard combination, both flag values, the destination-vector bit and all eight priorities, under three priority maps including one with equal class fields. Small pool thresholds put the fill, refusal, release and saturation corners only a few frames apart. The full 4×64 threshold of 256 is also filled to its last pointer.

// File: rtl/avbc_pkg.sv
package avbc_pkg;

    localparam int REG_W = 16;
    localparam int PRI_W = 3;
    localparam int THR_W = 10;

    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_LOW    = 2'd1,
        CLS_HIGH   = 2'd2
    } avb_class_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_STD = 2'd1,
        MODE_ENH = 2'd2,
        MODE_SEC = 2'd3
    } port_mode_e;

    typedef struct packed {
        logic [PRI_W-1:0] hi_fpri;
        logic [PRI_W-1:0] hi_qpri;
        logic [PRI_W-1:0] lo_fpri;
        logic [PRI_W-1:0] lo_qpri;
    } prio_map_t;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             mgmt_en;
    } pool_cfg_t;

    typedef struct packed {
        port_mode_e mode;
        logic       filt_bad;
        logic       drop_bad;
    } port_cfg_t;

    localparam logic [REG_W-1:0] PRIMAP_RST = 16'h5342;

endpackage

// File: rtl/avbc_regs.sv
module avbc_regs
    import avbc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output prio_map_t                 map_o,
    output pool_cfg_t                 pool_o,
    output port_cfg_t [NUM_PORTS-1:0] port_o
);

    typedef struct packed {
        prio_map_t                 map;
        pool_cfg_t                 pool;
        port_cfg_t [NUM_PORTS-1:0] port;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[13], wdata[11], wdata[3], wdata[7], wdata[9:0]};

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(0)) begin
                r_d.map.hi_fpri = wdata[14:12];
                r_d.map.hi_qpri = wdata[10:8];
                r_d.map.lo_fpri = wdata[6:4];
                r_d.map.lo_qpri = wdata[2:0];
            end else if (addr == ADDR_W'(1)) begin
                r_d.pool.thr     = wdata[THR_W-1:0];
                r_d.pool.mgmt_en = wdata[15];
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr == ADDR_W'(p + 2)) begin
                    r_d.port[p].mode     = port_mode_e'(wdata[15:14]);
                    r_d.port[p].filt_bad = wdata[12];
                    r_d.port[p].drop_bad = wdata[10];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q              <= '0;
            r_q.map.hi_fpri  <= PRIMAP_RST[14:12];
            r_q.map.hi_qpri  <= PRIMAP_RST[10:8];
            r_q.map.lo_fpri  <= PRIMAP_RST[6:4];
            r_q.map.lo_qpri  <= PRIMAP_RST[2:0];
        end else begin
            r_q <= r_d;
        end
    end

    assign map_o  = r_q.map;
    assign pool_o = r_q.pool;
    assign port_o = r_q.port;

endmodule

// File: rtl/avbc_classify.sv
module avbc_classify
    import avbc_pkg::*;
(
    input  prio_map_t        map_i,
    input  port_cfg_t        pcfg_i,
    input  logic [PRI_W-1:0] pri_i,
    input  logic             static_i,
    input  logic             self_in_dst_i,
    input  logic             mgmt_i,
    input  logic             mgmt_pool_i,
    output avb_class_e       cls_o,
    output logic [PRI_W-1:0] qpri_o,
    output logic             need_ptr_o,
    output logic             bad_drop_o
);

    logic hi_hit, lo_hit, any_hit, extra_ok, good, bad, as_stream;

    always_comb begin
        // high class wins when both fields hold the same priority
        hi_hit  = (pri_i == map_i.hi_fpri);
        lo_hit  = (pri_i == map_i.lo_fpri) && !hi_hit;
        any_hit = hi_hit || lo_hit;

        unique case (pcfg_i.mode)
            MODE_STD: extra_ok = 1'b1;
            MODE_ENH: extra_ok = static_i;
            MODE_SEC: extra_ok = static_i && self_in_dst_i;
            default:  extra_ok = 1'b0;
        endcase

        good = (pcfg_i.mode != MODE_OFF) && any_hit && extra_ok;
        bad  = (pcfg_i.mode != MODE_OFF) && any_hit && !extra_ok;

        bad_drop_o = bad && pcfg_i.drop_bad;
        as_stream  = good || (bad && !pcfg_i.drop_bad && !pcfg_i.filt_bad);

        if (as_stream) begin
            cls_o  = hi_hit ? CLS_HIGH : CLS_LOW;
            qpri_o = hi_hit ? map_i.hi_qpri : map_i.lo_qpri;
        end else begin
            cls_o  = CLS_LEGACY;
            qpri_o = pri_i;
        end

        need_ptr_o = !bad_drop_o && (as_stream || (mgmt_i && mgmt_pool_i));
    end

endmodule

// File: rtl/avbc_iso_pool.sv
module avbc_iso_pool
    import avbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_i,
    input  logic             req_i,
    input  logic             rel_i,
    output logic             grant_o
);

    logic [THR_W-1:0] cnt_d, cnt_q;
    logic             room, draw;

    always_comb begin
        room    = (thr_i == '0) || (cnt_q < thr_i);
        grant_o = req_i && room;
        draw    = grant_o && (thr_i != '0);
        cnt_d   = cnt_q + THR_W'(draw);
        if (rel_i && (cnt_d != '0)) begin
            cnt_d = cnt_d - THR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !draw && cnt_q == '0) |=> (cnt_q == '0));

    // R8
    draw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (draw && !rel_i) |=> (cnt_q == $past(cnt_q) + THR_W'(1)));

    // R11
    zero_thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '0 && !rel_i) |=> $stable(cnt_q));

endmodule

// File: rtl/avb_frame_classifier.sv
module avb_frame_classifier
    import avbc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = $clog2(NUM_PORTS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 frm_valid,
    input  logic [PRI_W-1:0]     frm_pri,
    input  logic [PORT_W-1:0]    frm_src,
    input  logic [NUM_PORTS-1:0] frm_dst_vec,
    input  logic                 frm_static_avb,
    input  logic                 frm_mgmt,
    input  logic                 ptr_release,
    output logic                 res_valid,
    output logic [1:0]           res_class,
    output logic [PRI_W-1:0]     res_qpri,
    output logic                 res_admit
);

    typedef struct packed {
        logic             valid;
        avb_class_e       cls;
        logic [PRI_W-1:0] qpri;
        logic             admit;
    } res_t;

    prio_map_t                 map;
    pool_cfg_t                 pool;
    port_cfg_t [NUM_PORTS-1:0] ports;
    port_cfg_t                 sel_cfg;
    logic                      self_bit;
    avb_class_e                cls;
    logic [PRI_W-1:0]          qpri;
    logic                      need_ptr, bad_drop, grant;
    res_t                      res_d, res_q;

    avbc_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .map_o (map),
        .pool_o(pool),
        .port_o(ports)
    );

    always_comb begin
        sel_cfg  = '0;
        self_bit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (frm_src == PORT_W'(p)) begin
                sel_cfg  = ports[p];
                self_bit = frm_dst_vec[p];
            end
        end
    end

    avbc_classify u_cls (
        .map_i        (map),
        .pcfg_i       (sel_cfg),
        .pri_i        (frm_pri),
        .static_i     (frm_static_avb),
        .self_in_dst_i(self_bit),
        .mgmt_i       (frm_mgmt),
        .mgmt_pool_i  (pool.mgmt_en),
        .cls_o        (cls),
        .qpri_o       (qpri),
        .need_ptr_o   (need_ptr),
        .bad_drop_o   (bad_drop)
    );

    avbc_iso_pool u_pool (
        .clk    (clk),
        .rst_n  (rst_n),
        .thr_i  (pool.thr),
        .req_i  (frm_valid && need_ptr),
        .rel_i  (ptr_release),
        .grant_o(grant)
    );

    always_comb begin
        res_d = '0;
        if (frm_valid) begin
            res_d.valid = 1'b1;
            res_d.cls   = cls;
            res_d.qpri  = qpri;
            res_d.admit = !bad_drop && (!need_ptr || grant);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_class = res_q.cls;
    assign res_qpri  = res_q.qpri;
    assign res_admit = res_q.admit;

    // R12
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);

    // R7
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && bad_drop) |=> (!res_admit && res_class == CLS_LEGACY));

endmodule

// File: tb/tb_avb_frame_classifier.sv
module tb_avb_frame_classifier;
    localparam int NP = 4;
    localparam int PW = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          frm_valid = 1'b0;
    logic [2:0]    frm_pri = '0;
    logic [PW-1:0] frm_src = '0;
    logic [NP-1:0] frm_dst_vec = '0;
    logic          frm_static_avb = 1'b0;
    logic          frm_mgmt = 1'b0;
    logic          ptr_release = 1'b0;
    logic          res_valid, res_admit;
    logic [1:0]    res_class;
    logic [2:0]    res_qpri;

    always #2.5 clk = ~clk;

    avb_frame_classifier #(.NUM_PORTS(NP)) dut (.*);

    int vec_cnt = 0, err_cnt = 0;
    bit done = 0;
    int m_cnt = 0, m_thr = 0;
    logic m_mgmt_en = 0;
    logic [15:0] m_map = 16'h5342;
    logic [15:0] m_port [NP];

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (a == 0) m_map = d;
        else if (a == 1) begin m_thr = int'(d[9:0]); m_mgmt_en = d[15]; end
        else if (a - 2 < NP) m_port[a-2] = d;
    endtask

    task automatic release_ptr();
        @(negedge clk);
        ptr_release = 1;
        @(negedge clk);
        ptr_release = 0;
        if (m_cnt > 0) m_cnt--;
    endtask

    task automatic send(input int pri, input int src, input logic [NP-1:0] dst,
                        input logic st, input logic mg, input logic rel, input string tag);
        logic [15:0] c;
        int mode, hf, hq, lf, lq, ecls, eq, nxt;
        logic hm, lm, ex, good, bad, strm, bdrop, need, ok, eadm;
        c = m_port[src]; mode = int'(c[15:14]);
        hf = int'(m_map[14:12]); hq = int'(m_map[10:8]);
        lf = int'(m_map[6:4]);   lq = int'(m_map[2:0]);
        hm = (pri == hf); lm = (pri == lf) && !hm;
        ex = (mode == 1) ? 1'b1 : (mode == 2) ? st : (st && dst[src]);
        good = (mode != 0) && (hm || lm) && ex;
        bad  = (mode >= 2) && (hm || lm) && !ex;
        bdrop = bad && c[10];
        strm = good || (bad && !c[10] && !c[12]);
        ecls = strm ? (hm ? 2 : 1) : 0;
        eq   = strm ? (hm ? hq : lq) : pri;
        need = !bdrop && (strm || (mg && m_mgmt_en));
        ok   = !need || (m_thr == 0) || (m_cnt < m_thr);
        eadm = !bdrop && ok;
        nxt  = m_cnt + ((need && ok && m_thr != 0) ? 1 : 0);
        if (rel && nxt > 0) nxt--;
        @(negedge clk);
        vec_cnt++;
        if (res_valid !== 1'b0) begin
            err_cnt++;
            $display("FAIL R12 idle res_valid=%0b expected 0", res_valid);
        end
        frm_valid = 1; frm_pri = 3'(pri); frm_src = PW'(src); frm_dst_vec = dst;
        frm_static_avb = st; frm_mgmt = mg; ptr_release = rel;
        @(negedge clk);
        frm_valid = 0; ptr_release = 0;
        vec_cnt++;
        if (res_valid !== 1'b1 || res_class !== 2'(ecls) || res_qpri !== 3'(eq) || res_admit !== eadm) begin
            err_cnt++;
            $display("FAIL %s pri=%0d src=%0d mode=%0d: got v=%0b cls=%0d q=%0d adm=%0b expected v=1 cls=%0d q=%0d adm=%0b",
                     tag, pri, src, mode, res_valid, res_class, res_qpri, res_admit, ecls, eq, eadm);
        end
        m_cnt = nxt;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        err_cnt++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] maps [3];
        maps[0] = 16'h5342; maps[1] = 16'h3726; maps[2] = 16'h2721;
        for (int p = 0; p < NP; p++) m_port[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, output idle
        @(negedge clk);
        vec_cnt++;
        if (res_valid !== 1'b0) begin
            err_cnt++;
            $display("FAIL R1 res_valid=%0b expected 0", res_valid);
        end
        // R1: default mode 0 is legacy even for priority 5
        send(5, 0, '0, 1, 0, 0, "R1_mode0");
        // R1: default map with a standard port
        wr(2, 16'h4000);
        send(5, 0, '0, 0, 0, 0, "R1_default_hi");
        send(4, 0, '0, 0, 0, 0, "R1_default_lo");
        wr(2, 16'h0000);

        // R2 R3 R4 R5 R6 R7: full sweep with threshold 0 (R11)
        for (int mi = 0; mi < 3; mi++) begin
            if (mi != 0) wr(0, maps[mi]);
            for (int mode = 0; mode < 4; mode++) begin
                for (int fd = 0; fd < 4; fd++) begin
                    for (int src = 0; src < NP; src++) begin
                        wr(2 + src, {2'(mode), 1'b0, fd[1], 1'b0, fd[0], 10'd0});
                        for (int st = 0; st < 2; st++) begin
                            for (int db = 0; db < 2; db++) begin
                                logic [NP-1:0] dv;
                                dv = db[0] ? NP'(0) : '1;
                                dv[src] = db[0];
                                for (int pri = 0; pri < 8; pri++) begin
                                    send(pri, src, dv, st[0], 1'b0, 1'b0,
                                         mode == 0 ? "R2" : mode == 1 ? (mi == 2 ? "R4" : "R3") :
                                         mode == 2 ? "R5_R7" : "R6_R7");
                                end
                            end
                        end
                    end
                end
            end
        end

        // pool tests on port 0, standard mode, default map
        wr(0, 16'h5342);
        wr(2, 16'h4000);
        wr(1, 16'd5);
        for (int i = 0; i < 7; i++) send(5, 0, '0, 0, 0, 0, "R8_fill");
        send(0, 0, '0, 0, 0, 0, "R8_legacy_free");
        send(0, 0, '0, 0, 1, 0, "R10_mgmt_off");
        release_ptr(); release_ptr();
        for (int i = 0; i < 3; i++) send(4, 0, '0, 0, 0, 0, "R9_after_release");
        send(5, 0, '0, 0, 0, 1, "R9_same_cycle");
        send(5, 0, '0, 0, 0, 0, "R9_same_cycle_full");
        for (int i = 0; i < 10; i++) release_ptr();
        for (int i = 0; i < 6; i++) send(5, 0, '0, 0, 0, 0, "R9_saturate");
        for (int i = 0; i < 10; i++) release_ptr();
        wr(1, 16'h8005);
        for (int i = 0; i < 6; i++) send(1, 0, '0, 0, 1, 0, "R10_mgmt_on");
        for (int i = 0; i < 10; i++) release_ptr();
        wr(1, 16'h8000);
        for (int i = 0; i < 8; i++) send(5, 0, '0, 0, i[0], 0, "R11_zero_thr");
        wr(1, 16'd2);
        for (int i = 0; i < 3; i++) send(5, 0, '0, 0, 0, 0, "R11_no_growth");
        for (int i = 0; i < 4; i++) release_ptr();
        // R12: write and frame in the same cycle uses old config
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(2); cfg_wdata = 16'h0000;
        frm_valid = 1; frm_pri = 3'd5; frm_src = '0; frm_dst_vec = '0;
        frm_static_avb = 0; frm_mgmt = 0;
        @(negedge clk);
        cfg_we = 0; frm_valid = 0;
        vec_cnt++;
        if (res_class !== 2'd2 || res_qpri !== 3'd3 || res_admit !== 1'b1) begin
            err_cnt++;
            $display("FAIL R12 same-cycle write cls=%0d q=%0d adm=%0b expected 2 3 1", res_class, res_qpri, res_admit);
        end
        m_port[0] = 16'h0000; m_cnt = 1;
        send(5, 0, '0, 0, 0, 0, "R12_new_config");
        release_ptr();
        // R8 with port count times 64
        wr(2, 16'h4000);
        wr(1, 16'(NP << 6));
        for (int i = 0; i < (NP << 6) + 2; i++) send(5, 0, '0, 0, 0, 0, "R8_full_pool");
        finish_run();
    end
endmodule